// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns each 32-bit bus address into a one-hot select. There are five possible targets: four external chip regions, called A, B, C and D, and one fixed internal register window. Software programs each chip region through 16-bit configuration registers. Each chip has an option word, which holds enable, size, read-only and protection fields, and a base word. One shared word supplies the top three address bits for every chip. A control word can widen the unprotected part of a region or switch chip D to large sizes. The fields interact: a value in one register changes how a field in another register is read.

Every valid access is checked against the attributes of the region that wins the decode. A write to a read-only area, or a user-mode access to a supervisor-only area, produces no select. It sets a sticky flag in the status register instead. The flags stay set until software writes a 1 to them. The select and the flags are registered, so they appear one clock after the access is presented.

Top module: `csel_decoder`

## Requirements
- R1: After reset the status register reads 0x1C, chips B, C and D are disabled, and chip A is enabled with base 0 across the whole 4 GB space. Chip A keeps the whole space until its base word is written.
- R2: Configuration words are chosen by `cfg_addr`: 0–3 are option A–D, 4–7 are base A–D, 8 is upper base, 9 is control and 10 is status. Writes are masked with these values: option A 0x81FF, options B and C 0xF9FF, bases 0xFFFE, control 0x7F55. Option D and upper base are stored unmasked. `cfg_rdata` returns the word at `cfg_addr` one clock later.
- R3: A chip hits when option bit 0 is set and base <= address < base + size. The base takes base-word bits 15:1 at address bits 27:13. The size is 128 KB (A, B) or 32 KB (C, D) shifted left by option bits 3:1.
- R4: When upper-base bit 15 is set, address bits 31:29 of each base come from the upper-base word: bits 14:12 for A, 10:8 for B, 6:4 for C and 2:0 for D.
- R5: When control bit 6 and option-D bit 9 are both set, chip D's size is 8 MB shifted left by option-D bit 1.
- R6: Decode priority is D, then A, then the internal window (0xFFFFF000 up to but not including 0xFFFFFE00), then B, then C. `sel_o` bits are A=0, B=1, C=2, D=3, internal=4.
- R7: `sel_o` is registered. It is one-hot one clock after a valid access. It is zero after a clock with no valid access or with an unmapped address.
- R8: Option bit 15 makes the whole region read-only. A write there gives no select and sets status bit 6.
- R9: For B, C and D, the protected area begins at base + 32 KB shifted left by option bits 12:11. When option bit 14 is set, a user-mode access at or above that point gives no select and sets status bit 7.
- R10: When control bit 14 and the chip's own control bit are both set (bit 0 for B, bit 2 for C, bit 4 for D), the unprotected shift gains 4.
- R11: When option bit 13 is set, a write into the protected area gives no select and sets status bit 6.
- R12: Status bits 7:5 are sticky. A status write clears only the positions written with 1 and never sets them. Status bits 4:0 take the written value. A flag set in the same clock as a clearing write stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word index |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Registered readback of the indexed word |
| bus_valid | input | 1 | Bus access present |
| bus_addr | input | 32 | Bus address |
| bus_write | input | 1 | Access is a write |
| bus_super | input | 1 | Access is in supervisor mode |
| sel_o | output | 5 | Registered one-hot select |
| status_o | output | 8 | Status register with sticky violation flags |

## Verification
The hardest cases to reach are the ones where the result depends on two or three registers together. Examples are chip D's large-size mode, the widened unprotected area, and relocation through the upper-base word. In each of these, a single register change flips a hit into a miss, or a violation into a clean select. The stimulus first places regions at overlapping and disjoint bases to show the priority order. It then walks one address across a protection boundary while toggling a single control or option bit. After each violation, status is cleared through a partial write, so that both the sticky rule and the write-one-to-clear rule are observed.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int ADDR_W  = 32;
  localparam int REG_W   = 16;
  localparam int NCHIP   = 4;
  localparam int SEL_W   = NCHIP + 1;
  localparam int IDX_W   = 4;
  localparam int ST_W    = 8;

  localparam logic [IDX_W-1:0] IDX_OPT0  = 4'd0;
  localparam logic [IDX_W-1:0] IDX_BASE0 = 4'd4;
  localparam logic [IDX_W-1:0] IDX_UPPER = 4'd8;
  localparam logic [IDX_W-1:0] IDX_CTRL  = 4'd9;
  localparam logic [IDX_W-1:0] IDX_STAT  = 4'd10;

  localparam logic [REG_W-1:0] MASK_OPT_A  = 16'h81FF;
  localparam logic [REG_W-1:0] MASK_OPT_BC = 16'hF9FF;
  localparam logic [REG_W-1:0] MASK_BASE   = 16'hFFFE;
  localparam logic [REG_W-1:0] MASK_CTRL   = 16'h7F55;

  localparam logic [ADDR_W-1:0] INT_BASE = 32'hFFFF_F000;
  localparam logic [ADDR_W-1:0] INT_SIZE = 32'h0000_0E00;
  localparam logic [ST_W-1:0]   STAT_RST = 8'h1C;
  localparam logic [REG_W-1:0]  OPT_A_RST = 16'h0001;

  localparam int ST_PRIV = 7;
  localparam int ST_WP   = 6;
endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [IDX_W-1:0]           idx,
  input  logic [REG_W-1:0]           wdata,
  input  logic                       set_priv,
  input  logic                       set_wp,
  output logic [NCHIP-1:0][REG_W-1:0] opt,
  output logic [NCHIP-1:0][REG_W-1:0] base,
  output logic [REG_W-1:0]           upper,
  output logic [REG_W-1:0]           ctrl,
  output logic [ST_W-1:0]            status,
  output logic                       a_full,
  output logic [REG_W-1:0]           rdata
);
  logic [ST_W-1:0]  status_d;
  logic [REG_W-1:0] rd_mux;

  function automatic logic [REG_W-1:0] opt_mask(input int c);
    if (c == 0)      return MASK_OPT_A;
    else if (c == 3) return 16'hFFFF;
    else             return MASK_OPT_BC;
  endfunction

  for (genvar c = 0; c < NCHIP; c++) begin : g_chip
    always_ff @(posedge clk) begin
      if (rst) begin
        opt[c]  <= (c == 0) ? OPT_A_RST : '0;
        base[c] <= '0;
      end else if (we) begin
        if (idx == IDX_OPT0 + IDX_W'(c))  opt[c]  <= wdata & opt_mask(c);
        if (idx == IDX_BASE0 + IDX_W'(c)) base[c] <= wdata & MASK_BASE;
      end
    end
  end

  always_comb begin
    status_d = status;
    if (we && idx == IDX_STAT) begin
      status_d[4:0] = wdata[4:0];
      status_d[7:5] = status[7:5] & ~wdata[7:5];
    end
    if (set_priv) status_d[ST_PRIV] = 1'b1;
    if (set_wp)   status_d[ST_WP]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upper  <= '0;
      ctrl   <= '0;
      status <= STAT_RST;
      a_full <= 1'b1;
    end else begin
      status <= status_d;
      if (we && idx == IDX_UPPER) upper <= wdata;
      if (we && idx == IDX_CTRL)  ctrl  <= wdata & MASK_CTRL;
      if (we && idx == IDX_BASE0) a_full <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (idx < IDX_BASE0)          rd_mux = opt[idx[1:0]];
    else if (idx < IDX_UPPER)     rd_mux = base[idx[1:0]];
    else if (idx == IDX_UPPER)    rd_mux = upper;
    else if (idx == IDX_CTRL)     rd_mux = ctrl;
    else if (idx == IDX_STAT)     rd_mux = {{(REG_W-ST_W){1'b0}}, status};
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/csel_window.sv
module csel_window
  import csel_pkg::*;
#(
  parameter int UNIT_LOG = 17,
  parameter int PROT_LOG = 15,
  parameter int BIG_LOG  = 23,
  parameter bit HAS_ATTR = 1'b1,
  parameter bit HAS_BIG  = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  opt,
  input  logic [REG_W-1:0]  base_reg,
  input  logic [2:0]        up_bits,
  input  logic              up_en,
  input  logic              ext,
  input  logic              big_en,
  input  logic              full,
  output logic              hit,
  output logic              ro_all,
  output logic              in_prot,
  output logic              prot_super,
  output logic              prot_ro
);
  localparam int XW = ADDR_W + 1;
  logic [XW-1:0] a_x, base_x, size_x, unp_x;
  int            sh;

  always_comb begin
    a_x    = {1'b0, addr};
    base_x = '0;
    base_x[27:13] = base_reg[15:1];
    if (up_en) base_x[31:29] = up_bits;
    sh = UNIT_LOG + int'(opt[3:1]);
    if (HAS_BIG && big_en && opt[9]) sh = BIG_LOG + int'(opt[1]);
    size_x = XW'(1) << sh;
    if (full) begin
      base_x = '0;
      size_x = XW'(1) << ADDR_W;
    end
    unp_x = XW'(1) << (PROT_LOG + int'({ext, opt[12:11]}));
  end

  assign hit        = (opt[0] || full) && (a_x >= base_x) && (a_x < base_x + size_x);
  assign ro_all     = opt[15];
  assign in_prot    = HAS_ATTR && (a_x >= base_x + unp_x);
  assign prot_super = HAS_ATTR && opt[14];
  assign prot_ro    = HAS_ATTR && opt[13];
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              bus_valid,
  input  logic [31:0]       bus_addr,
  input  logic              bus_write,
  input  logic              bus_super,
  output logic [4:0]        sel_o,
  output logic [7:0]        status_o
);
  logic [NCHIP-1:0][REG_W-1:0] opt, base;
  logic [REG_W-1:0] upper, ctrl;
  logic             a_full;
  logic [NCHIP-1:0] hit, ro_all, in_prot, p_sup, p_ro, ext;
  logic             int_hit, set_priv, set_wp, viol_wp, viol_pv;
  logic [SEL_W-1:0] pick, sel_q;
  int               win;

  csel_regs u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_addr), .wdata(cfg_wdata),
    .set_priv(set_priv), .set_wp(set_wp), .opt(opt), .base(base),
    .upper(upper), .ctrl(ctrl), .status(status_o), .a_full(a_full),
    .rdata(cfg_rdata)
  );

  always_comb begin
    ext[0] = 1'b0;
    for (int c = 1; c < NCHIP; c++) ext[c] = ctrl[14] & ctrl[2*(c-1)];
  end

  for (genvar c = 0; c < NCHIP; c++) begin : g_win
    csel_window #(
      .UNIT_LOG ((c < 2) ? 17 : 15),
      .PROT_LOG (15),
      .BIG_LOG  (23),
      .HAS_ATTR (c != 0),
      .HAS_BIG  (c == NCHIP-1)
    ) u_win (
      .addr(bus_addr), .opt(opt[c]), .base_reg(base[c]),
      .up_bits(upper[14-4*c -: 3]), .up_en(upper[15]), .ext(ext[c]),
      .big_en(ctrl[6]), .full((c == 0) && a_full),
      .hit(hit[c]), .ro_all(ro_all[c]), .in_prot(in_prot[c]),
      .prot_super(p_sup[c]), .prot_ro(p_ro[c])
    );
  end

  assign int_hit = (bus_addr >= INT_BASE) && ({1'b0, bus_addr} < {1'b0, INT_BASE} + {1'b0, INT_SIZE});

  always_comb begin
    pick = '0;
    win  = -1;
    if (hit[3])       begin pick[3] = 1'b1; win = 3; end
    else if (hit[0])  begin pick[0] = 1'b1; win = 0; end
    else if (int_hit) begin pick[4] = 1'b1; end
    else if (hit[1])  begin pick[1] = 1'b1; win = 1; end
    else if (hit[2])  begin pick[2] = 1'b1; win = 2; end
    viol_wp = 1'b0;
    viol_pv = 1'b0;
    if (win >= 0) begin
      viol_wp = bus_write && (ro_all[win] || (in_prot[win] && p_ro[win]));
      viol_pv = !bus_super && in_prot[win] && p_sup[win];
    end
  end

  assign set_wp   = bus_valid && viol_wp;
  assign set_priv = bus_valid && viol_pv;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= (bus_valid && !viol_wp && !viol_pv) ? pick : '0;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/csel_checker.sv
module csel_checker (
  input logic        clk,
  input logic        rst,
  input logic        cfg_we,
  input logic [3:0]  cfg_addr,
  input logic [15:0] cfg_wdata,
  input logic        bus_valid,
  input logic [4:0]  sel_o,
  input logic [7:0]  status_o
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(sel_o)); // R6
  AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (rst) !bus_valid |=> (sel_o == 5'd0)); // R7
  AST_RESET_STATUS: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> (status_o == 8'h1C)); // R1
  AST_PRIV_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (status_o[7] && !(cfg_we && cfg_addr == 4'd10 && cfg_wdata[7])) |=> status_o[7]); // R12
  AST_WP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (status_o[6] && !(cfg_we && cfg_addr == 4'd10 && cfg_wdata[6])) |=> status_o[6]); // R12
  AST_PRIV_BLOCKS: assert property (@(posedge clk) disable iff (rst) $rose(status_o[7]) |-> (sel_o == 5'd0)); // R9
  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (rst) $rose(status_o[6]) |-> (sel_o == 5'd0)); // R8
endmodule

bind csel_decoder csel_checker u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .bus_valid(bus_valid), .sel_o(sel_o), .status_o(status_o)
);

// File: tb/sim_csel_decoder.sv
`timescale 1ns/1ps
module sim_csel_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_write = 1'b0;
  logic        bus_super = 1'b0;
  logic [4:0]  sel_o;
  logic [7:0]  status_o;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  csel_decoder u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_super(bus_super), .sel_o(sel_o), .status_o(status_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [3:0] idx, input logic [15:0] exp);
    @(negedge clk);
    cfg_addr = idx;
    @(posedge clk);
    @(negedge clk);
    check(req, {16'h0, cfg_rdata}, {16'h0, exp});
  endtask

  task automatic acc(input string req, input logic [31:0] a, input bit w, input bit sup,
                     input logic [4:0] exp_sel, input logic [7:0] exp_st);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_write = w; bus_super = sup;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    check(req, {27'h0, sel_o}, {27'h0, exp_sel});
    check(req, {24'h0, status_o}, {24'h0, exp_st});
  endtask

  task automatic t_reset;
    check("R1 status", {24'h0, status_o}, 32'h1C);
    check("R1 sel", {27'h0, sel_o}, 32'h0);
    acc("R1 A spans all", 32'h1234_5678, 0, 1, 5'h01, 8'h1C);
    acc("R1 A over int window", 32'hFFFF_F100, 0, 1, 5'h01, 8'h1C);
    acc("R1 A top", 32'hFFFF_FFFF, 1, 0, 5'h01, 8'h1C);
  endtask

  task automatic t_masks;
    wr(4'd0, 16'hFFFF); rd_check("R2 optA", 4'd0, 16'h81FF);
    wr(4'd1, 16'hFFFF); rd_check("R2 optB", 4'd1, 16'hF9FF);
    wr(4'd3, 16'hFFFF); rd_check("R2 optD", 4'd3, 16'hFFFF);
    wr(4'd4, 16'hFFFF); rd_check("R2 baseA", 4'd4, 16'hFFFE);
    wr(4'd9, 16'hFFFF); rd_check("R2 ctrl", 4'd9, 16'h7F55);
    wr(4'd1, 16'h0000); wr(4'd3, 16'h0000); wr(4'd9, 16'h0000);
  endtask

  task automatic t_window;
    wr(4'd0, 16'h0003); wr(4'd4, 16'h2001);
    acc("R3 A first", 32'h0200_0000, 0, 1, 5'h01, 8'h1C);
    acc("R3 A last", 32'h0203_FFFF, 0, 1, 5'h01, 8'h1C);
    acc("R3 A past end", 32'h0204_0000, 0, 1, 5'h00, 8'h1C);
    acc("R3 A below base", 32'h01FF_FFFF, 0, 1, 5'h00, 8'h1C);
    acc("R6 int low", 32'hFFFF_F100, 0, 1, 5'h10, 8'h1C);
    acc("R6 int last", 32'hFFFF_FDFF, 0, 1, 5'h10, 8'h1C);
    acc("R6 int end", 32'hFFFF_FE00, 0, 1, 5'h00, 8'h1C);
    acc("R6 int below", 32'hFFFF_EFFF, 0, 1, 5'h00, 8'h1C);
  endtask

  task automatic t_priority;
    wr(4'd7, 16'h2001); wr(4'd3, 16'h0001);
    acc("R6 D over A", 32'h0200_0010, 0, 1, 5'h08, 8'h1C);
    acc("R3 D 32K end", 32'h0200_8000, 0, 1, 5'h01, 8'h1C);
    wr(4'd5, 16'h2001); wr(4'd1, 16'h0001);
    acc("R6 A over B", 32'h0201_0000, 0, 1, 5'h01, 8'h1C);
    wr(4'd5, 16'h4001);
    acc("R3 B alone", 32'h0400_0000, 0, 1, 5'h02, 8'h1C);
    wr(4'd6, 16'h4001); wr(4'd2, 16'h0001);
    acc("R6 B over C", 32'h0400_0000, 0, 1, 5'h02, 8'h1C);
    wr(4'd6, 16'h6001);
    acc("R3 C alone", 32'h0600_0000, 0, 1, 5'h04, 8'h1C);
    wr(4'd3, 16'h0000);
  endtask

  task automatic t_upper;
    wr(4'd8, 16'h8100);
    acc("R4 B raised", 32'h2400_0000, 0, 1, 5'h02, 8'h1C);
    acc("R4 B left old", 32'h0400_0000, 0, 1, 5'h00, 8'h1C);
    wr(4'd8, 16'h0100);
    acc("R4 disabled", 32'h0400_0000, 0, 1, 5'h02, 8'h1C);
    wr(4'd8, 16'h0000);
  endtask

  task automatic t_big;
    wr(4'd7, 16'h0001); wr(4'd3, 16'h0203);
    acc("R5 off small", 32'h00FF_0000, 0, 1, 5'h00, 8'h1C);
    wr(4'd9, 16'h0040);
    acc("R5 on 16MB", 32'h00FF_FFFF, 0, 1, 5'h08, 8'h1C);
    acc("R5 on end", 32'h0100_0000, 0, 1, 5'h00, 8'h1C);
    wr(4'd9, 16'h0000);
  endtask

  task automatic t_readonly;
    wr(4'd0, 16'h8003);
    acc("R8 write blocked", 32'h0200_0000, 1, 1, 5'h00, 8'h5C);
    acc("R8 read ok", 32'h0200_0000, 0, 1, 5'h01, 8'h5C);
    wr(4'd10, 16'h0000);
    check("R12 zero write keeps flag", {24'h0, status_o}, 32'h40);
    wr(4'd10, 16'h005C);
    check("R12 clear", {24'h0, status_o}, 32'h1C);
    wr(4'd10, 16'h00FC);
    check("R12 no set by write", {24'h0, status_o}, 32'h1C);
    wr(4'd0, 16'h0003);
  endtask

  task automatic t_protect;
    wr(4'd9, 16'h0000); wr(4'd7, 16'h0001); wr(4'd3, 16'h4007);
    acc("R9 user in prot", 32'h0001_0000, 0, 0, 5'h00, 8'h9C);
    acc("R9 super in prot", 32'h0001_0000, 0, 1, 5'h08, 8'h9C);
    acc("R9 user unprot", 32'h0000_1000, 0, 0, 5'h08, 8'h9C);
    wr(4'd10, 16'h009C);
    wr(4'd3, 16'h4807);
    acc("R9 field 64K", 32'h0000_C000, 0, 0, 5'h08, 8'h1C);
    acc("R9 field edge", 32'h0001_0000, 0, 0, 5'h00, 8'h9C);
    wr(4'd10, 16'h009C);
    wr(4'd3, 16'h4007); wr(4'd9, 16'h4010);
    acc("R10 D extended", 32'h0001_0000, 0, 0, 5'h08, 8'h1C);
    wr(4'd9, 16'h4001);
    acc("R10 other chip bit", 32'h0001_0000, 0, 0, 5'h00, 8'h9C);
    wr(4'd10, 16'h009C); wr(4'd9, 16'h0000);
    wr(4'd3, 16'h2007);
    acc("R11 prot write", 32'h0001_0000, 1, 0, 5'h00, 8'h5C);
    acc("R11 unprot write", 32'h0000_1000, 1, 0, 5'h08, 8'h5C);
    acc("R11 prot read", 32'h0001_0000, 0, 0, 5'h08, 8'h5C);
    wr(4'd10, 16'h005C);
    check("R12 cleared", {24'h0, status_o}, 32'h1C);
  endtask

  task automatic t_idle;
    @(negedge clk);
    bus_valid = 1'b0; bus_addr = 32'h0000_1000;
    @(posedge clk);
    @(negedge clk);
    check("R7 idle", {27'h0, sel_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_masks();
    t_window();
    t_priority();
    t_upper();
    t_big();
    t_readonly();
    t_protect();
    t_idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule